// File: doc/BRIEF.md
# Circular post-modify pointer unit

This block works out, for a load that uses post-increment or post-decrement addressing, the address the access goes to and the value the pointer register takes afterwards. The access always uses the pointer as it stands; the pointer then moves by one word (2 bytes) or two words (4 bytes), upward or downward.

A circular mode turns the pointer into a ring-buffer index. When the mode bit in the status word is set and the incoming pointer equals a programmable end register, the next pointer is reloaded from a programmable start register instead of being stepped. The reload rule is the same in both directions. To run a buffer downward, software therefore puts the low bound in the end register and the high bound in the start register. The two bound registers are written through a small configuration port. The address and next-pointer outputs are combinational in the current inputs and the stored bounds.

Top module: `modpm_addr_unit`

## Requirements
- R1: After a synchronous active-low reset, both bound registers read as 0x0000. With circular mode on, a pointer of 0x0000 therefore reloads to 0x0000.
- R2: `eff_addr` always equals `ptr_cur`, whatever the mode, size or direction.
- R3: With `acc_dbl`=0 the pointer moves by 2. With `acc_dbl`=1 it moves by 4.
- R4: With `dir_dec`=0 the step is added. With `dir_dec`=1 the step is subtracted. The arithmetic is 16-bit and wraps modulo 65536, so 0xFFFE+4 gives 0x0002 and 0x0000-2 gives 0xFFFE.
- R5: Circular mode is on exactly when bit 7 of `status_word` is 1. The other 15 bits of `status_word` have no effect on `ptr_next`.
- R6: With circular mode on and `ptr_cur` equal to the end register, `ptr_next` equals the start register. This holds for both directions and both sizes. With end=0x100 and start=0x108, stepping down by 2 from 0x108 gives 0x106, 0x104, 0x102, 0x100, 0x108.
- R7: With circular mode off, the pointer steps linearly even when it equals the end register. For example, 0x100 stepping down gives 0xFE, and 0x108 stepping up gives 0x10A.
- R8: A pointer that is not equal to the end register is always stepped linearly, even when it lies outside the two bounds.
- R9: A clock edge with `cfg_we`=1 loads `cfg_wdata` into the start register when `cfg_sel`=0, or into the end register when `cfg_sel`=1. The other register is left unchanged, and the new value is used from the following cycle on.
- R10: A clock edge with `cfg_we`=0 leaves both bound registers unchanged, whatever `cfg_sel` and `cfg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Bound register write enable |
| cfg_sel | input | 1 | Write target: 0 = start register, 1 = end register |
| cfg_wdata | input | 16 | Write data for the selected bound |
| ptr_cur | input | 16 | Pointer value before modification |
| acc_dbl | input | 1 | Access size: 0 = single word, 1 = double word |
| dir_dec | input | 1 | Direction: 0 = increment, 1 = decrement |
| status_word | input | 16 | Processor status word; bit 7 enables circular mode |
| eff_addr | output | 16 | Address used by the access |
| ptr_next | output | 16 | Pointer value after modification |

## Verification
Each combination of size and direction is walked around a ring with circular mode on, feeding every predicted next pointer back in as the next input. The walk shows that the reload fires only at the end register and lands on the start register. The same walks are then repeated with circular mode off, which separates a bound-triggered reload from plain stepping past the bounds. Single probes then cover the remaining cases: status words with every bit except bit 7 set, pointers outside the bounds, stepping past 0xFFFF and 0x0000, and writes with the enable low. These tell a correct decode of the mode bit and the equality test apart from a range test or a wrong bit, and show that a write lands only in the selected register.

// File: rtl/modpm_pkg.sv
// Package: shared defaults and encodings for the circular post-modify unit.
// Assumes all users take the pointer width from DEF_PTR_W unless overridden.
package modpm_pkg;
    localparam int unsigned DEF_PTR_W      = 16;
    localparam int unsigned DEF_STATUS_W   = 16;
    localparam int unsigned DEF_MODEN_BIT  = 7;
    localparam int unsigned DEF_WORD_BYTES = 2;
    localparam int unsigned NUM_BOUNDS     = 2;

    // Index of each bound register; also the value of the write select.
    typedef enum logic {
        BND_START = 1'b0,
        BND_END   = 1'b1
    } bound_sel_e;

    typedef enum logic {
        ACC_SINGLE = 1'b0,
        ACC_DOUBLE = 1'b1
    } acc_size_e;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;
endpackage

// File: rtl/modpm_bound_regs.sv
// Module: modpm_bound_regs
// Holds the start and end bound registers of the circular buffer.
// Assumes writes arrive one per cycle; the select indexes bound_sel_e.
// Reset is synchronous, active low, and clears every bound to zero.
module modpm_bound_regs
    import modpm_pkg::*;
#(
    parameter int unsigned PTR_W = DEF_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] start_q,
    output logic [PTR_W-1:0] end_q
);
    logic [PTR_W-1:0] bnd_q [NUM_BOUNDS];

    for (genvar gi = 0; gi < NUM_BOUNDS; gi++) begin : g_bnd
        // Purpose: load this bound when it is the selected write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bnd_q[gi] <= '0;
            end else if (wr_en && (wr_sel == gi[0])) begin
                bnd_q[gi] <= wr_data;
            end
        end
    end

    assign start_q = bnd_q[BND_START];
    assign end_q   = bnd_q[BND_END];
endmodule

// File: rtl/modpm_step_gen.sv
// Module: modpm_step_gen
// Produces the signed pointer adjustment, as a two's-complement value
// of pointer width, from the access size and the direction.
// Assumes a double access covers exactly two words.
module modpm_step_gen
    import modpm_pkg::*;
#(
    parameter int unsigned PTR_W      = DEF_PTR_W,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES
) (
    input  logic             acc_dbl,
    input  logic             dir_dec,
    output logic [PTR_W-1:0] delta
);
    localparam logic [PTR_W-1:0] STEP_ONE = PTR_W'(WORD_BYTES);
    localparam logic [PTR_W-1:0] STEP_TWO = PTR_W'(2 * WORD_BYTES);

    logic [PTR_W-1:0] magnitude;

    // Purpose: choose the step magnitude from the access size.
    always_comb begin
        magnitude = (acc_dbl == ACC_DOUBLE) ? STEP_TWO : STEP_ONE;
    end

    // Purpose: negate the magnitude for a downward step.
    always_comb begin
        delta = (dir_dec == STEP_DOWN) ? (~magnitude + 1'b1) : magnitude;
    end
endmodule

// File: rtl/modpm_next_sel.sv
// Module: modpm_next_sel
// Chooses between the linear next pointer and the start-bound reload.
// Assumes the end-bound test is exact equality on the unmodified pointer.
module modpm_next_sel
    import modpm_pkg::*;
#(
    parameter int unsigned PTR_W = DEF_PTR_W
) (
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [PTR_W-1:0] delta,
    input  logic             circ_on,
    input  logic [PTR_W-1:0] start_b,
    input  logic [PTR_W-1:0] end_b,
    output logic [PTR_W-1:0] ptr_out
);
    logic [PTR_W-1:0] linear_nx;
    logic             hit_end;

    // Purpose: linear pointer update, wrapping modulo 2**PTR_W.
    always_comb begin
        linear_nx = ptr_in + delta;
    end

    // Purpose: detect that the pointer sits on the end bound in circular mode.
    always_comb begin
        hit_end = circ_on && (ptr_in == end_b);
    end

    // Purpose: reload from the start bound on a hit, else take the linear value.
    always_comb begin
        ptr_out = hit_end ? start_b : linear_nx;
    end
endmodule

// File: rtl/modpm_addr_unit.sv
// Module: modpm_addr_unit (top)
// Post-modify address unit with an optional circular mode.
// The access address is the incoming pointer. The next pointer is stepped by
// one or two words, or reloaded from the start bound when circular mode is on
// and the pointer equals the end bound. Assumes the status word is stable for
// the cycle in which it is used.
module modpm_addr_unit
    import modpm_pkg::*;
#(
    parameter int unsigned PTR_W      = DEF_PTR_W,
    parameter int unsigned STATUS_W   = DEF_STATUS_W,
    parameter int unsigned MODEN_BIT  = DEF_MODEN_BIT,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [PTR_W-1:0]    cfg_wdata,
    input  logic [PTR_W-1:0]    ptr_cur,
    input  logic                acc_dbl,
    input  logic                dir_dec,
    input  logic [STATUS_W-1:0] status_word,
    output logic [PTR_W-1:0]    eff_addr,
    output logic [PTR_W-1:0]    ptr_next
);
    logic [PTR_W-1:0] bnd_start;
    logic [PTR_W-1:0] bnd_end;
    logic [PTR_W-1:0] step_delta;
    logic             circ_on;

    // Purpose: extract the circular-mode enable from the status word.
    always_comb begin
        circ_on = status_word[MODEN_BIT];
    end

    // Purpose: the access always uses the unmodified pointer.
    always_comb begin
        eff_addr = ptr_cur;
    end

    modpm_bound_regs #(.PTR_W(PTR_W)) u_bounds (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .start_q (bnd_start),
        .end_q   (bnd_end)
    );

    modpm_step_gen #(.PTR_W(PTR_W), .WORD_BYTES(WORD_BYTES)) u_step (
        .acc_dbl (acc_dbl),
        .dir_dec (dir_dec),
        .delta   (step_delta)
    );

    modpm_next_sel #(.PTR_W(PTR_W)) u_sel (
        .ptr_in  (ptr_cur),
        .delta   (step_delta),
        .circ_on (circ_on),
        .start_b (bnd_start),
        .end_b   (bnd_end),
        .ptr_out (ptr_next)
    );
endmodule

// File: rtl/modpm_addr_unit_chk.sv
// Module: modpm_addr_unit_chk
// Property checker for modpm_addr_unit, attached by bind below.
// Assumes inputs are stable around the rising clock edge.
module modpm_addr_unit_chk #(
    parameter int unsigned PTR_W      = 16,
    parameter int unsigned STATUS_W   = 16,
    parameter int unsigned MODEN_BIT  = 7,
    parameter int unsigned WORD_BYTES = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic                cfg_sel,
    input logic [PTR_W-1:0]    cfg_wdata,
    input logic [PTR_W-1:0]    ptr_cur,
    input logic                acc_dbl,
    input logic                dir_dec,
    input logic [STATUS_W-1:0] status_word,
    input logic [PTR_W-1:0]    ptr_next,
    input logic [PTR_W-1:0]    bnd_start,
    input logic [PTR_W-1:0]    bnd_end
);
    logic             on_end;
    logic [PTR_W-1:0] moved;
    logic [PTR_W-1:0] want_mag;

    // Purpose: derive the observed movement and the expected step size.
    always_comb begin
        on_end   = status_word[MODEN_BIT] && (ptr_cur == bnd_end);
        moved    = dir_dec ? (ptr_cur - ptr_next) : (ptr_next - ptr_cur);
        want_mag = acc_dbl ? PTR_W'(2 * WORD_BYTES) : PTR_W'(WORD_BYTES);
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bnd_start == '0) && (bnd_end == '0));

    a_r6_reload_start: assert property (@(posedge clk) disable iff (!rst_n)
        on_end |-> (ptr_next == bnd_start));

    // R3, R4, R7: linear step magnitude and sign whenever no reload applies.
    a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        !on_end |-> (moved == want_mag));

    a_r9_start_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (bnd_start == $past(cfg_wdata)) && $stable(bnd_end));

    a_r9_end_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (bnd_end == $past(cfg_wdata)) && $stable(bnd_start));

    a_r10_hold_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(bnd_start) && $stable(bnd_end));
endmodule

bind modpm_addr_unit modpm_addr_unit_chk #(
    .PTR_W(PTR_W), .STATUS_W(STATUS_W), .MODEN_BIT(MODEN_BIT), .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/sim_modpm_addr_unit.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the unit every cycle.
module sim_modpm_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] ptr_cur = '0;
    logic        acc_dbl = 1'b0;
    logic        dir_dec = 1'b0;
    logic [15:0] status_word = '0;
    logic [15:0] eff_addr;
    logic [15:0] ptr_next;

    int checks = 0;
    int errors = 0;
    int m_start = 0;
    int m_end = 0;
    logic [15:0] p;

    always #2.5 clk = ~clk;

    modpm_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ptr_cur(ptr_cur), .acc_dbl(acc_dbl),
        .dir_dec(dir_dec), .status_word(status_word),
        .eff_addr(eff_addr), .ptr_next(ptr_next)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, update model after it.
    task automatic cyc(input bit we, input bit sel, input int wd, input int ptr,
                       input bit dbl, input bit dec, input int sw,
                       input string tag, output logic [15:0] nxt);
        int step;
        int exp;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = 16'(wd);
        ptr_cur = 16'(ptr); acc_dbl = dbl; dir_dec = dec; status_word = 16'(sw);
        #1;
        step = dbl ? 4 : 2;
        if (sw[7] && ((ptr & 16'hFFFF) == m_end)) exp = m_start;
        else exp = dec ? ((ptr - step) & 16'hFFFF) : ((ptr + step) & 16'hFFFF);
        chk({tag, " R2 eff_addr"}, eff_addr, 16'(ptr));
        chk({tag, " ptr_next"}, ptr_next, 16'(exp));
        nxt = 16'(exp);
        @(posedge clk);
        if (we) begin
            if (sel) m_end = wd & 16'hFFFF;
            else m_start = wd & 16'hFFFF;
        end
    endtask

    task automatic walk(input int n, input bit dbl, input bit dec, input int sw,
                        input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, p, dbl, dec, sw, tag, p);
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: bounds are zero, so pointer 0 reloads to 0 in circular mode.
        cyc(0, 0, 0, 16'h0000, 0, 1, 16'h0080, "R1 reset bounds", d);
        // R9: program end then start.
        cyc(1, 1, 16'h0100, 16'h0040, 0, 0, 0, "R9 write end", d);
        cyc(1, 0, 16'h0108, 16'h0040, 0, 0, 0, "R9 write start", d);
        // R6: downward single ring 0x108..0x100 then reload.
        p = 16'h0108; walk(6, 0, 1, 16'h0080, "R6 dec single");
        chk("R6 dec single end", p, 16'h0106);
        p = 16'h0108; walk(4, 1, 1, 16'h0080, "R6 R3 dec double");
        chk("R6 R3 dec double end", p, 16'h0104);
        // R7: same bounds, mode off.
        p = 16'h0108; walk(6, 0, 1, 16'h0000, "R7 dec single off");
        chk("R7 dec single off end", p, 16'h00FC);
        p = 16'h0108; walk(4, 1, 1, 16'h0000, "R7 dec double off");
        chk("R7 dec double off end", p, 16'h00F8);
        // R9: swap bounds for upward rings.
        cyc(1, 0, 16'h0100, 16'h0000, 0, 0, 0, "R9 write start", d);
        cyc(1, 1, 16'h0108, 16'h0000, 0, 0, 0, "R9 write end", d);
        p = 16'h0100; walk(6, 0, 0, 16'h0080, "R6 inc single");
        chk("R6 inc single end", p, 16'h0102);
        p = 16'h0100; walk(4, 1, 0, 16'h0080, "R6 R3 inc double");
        chk("R6 R3 inc double end", p, 16'h0104);
        p = 16'h0100; walk(6, 0, 0, 16'h0000, "R7 inc single off");
        chk("R7 inc single off end", p, 16'h010C);
        p = 16'h0100; walk(4, 1, 0, 16'h0000, "R7 inc double off");
        chk("R7 inc double off end", p, 16'h0110);
        // R5: only bit 7 matters.
        cyc(0, 0, 0, 16'h0108, 0, 0, 16'hFF7F, "R5 other bits set", d);
        cyc(0, 0, 0, 16'h0108, 1, 1, 16'h0080, "R5 bit7 only", d);
        // R8: outside the bounds, no reload.
        cyc(0, 0, 0, 16'h0200, 0, 0, 16'hFFFF, "R8 above", d);
        cyc(0, 0, 0, 16'h00F0, 1, 1, 16'h0080, "R8 below", d);
        cyc(0, 0, 0, 16'h0106, 0, 1, 16'h0080, "R8 inside", d);
        // R4: 16-bit wrap of the arithmetic.
        cyc(0, 0, 0, 16'hFFFE, 1, 0, 16'h0000, "R4 top wrap", d);
        cyc(0, 0, 0, 16'h0000, 0, 1, 16'h0000, "R4 bottom wrap", d);
        // R10: writes with enable low are dropped; probe both bounds after.
        cyc(0, 0, 16'h0AAA, 16'h0010, 0, 0, 0, "R10 dropped start", d);
        cyc(0, 1, 16'h0BBB, 16'h0010, 0, 0, 0, "R10 dropped end", d);
        cyc(0, 0, 0, 16'h0108, 0, 0, 16'h0080, "R10 probe bounds", d);
        chk("R10 start kept", d, 16'h0100);
        // R9: a new start is used from the next cycle.
        cyc(1, 0, 16'h0300, 16'h0108, 0, 0, 16'h0080, "R9 old start", d);
        chk("R9 old start still used", d, 16'h0100);
        cyc(0, 0, 0, 16'h0108, 0, 0, 16'h0080, "R9 new start", d);
        chk("R9 new start used", d, 16'h0300);
        @(negedge clk);
        cfg_we = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule